// File: doc/BRIEF.md
# External-Memory Cache Control Registers with Invalidation Sweep

This block is the register slave that sits beside an external-memory cache. It presents two read-only words, one describing the cache and one giving its sizes, along with one control/status word and one write-triggered invalidate location. All of them are reached over a plain register bus that carries a word address, a write strobe, write data and combinational read data. The control word drives three datapath controls: the cache enable, the write-allocate policy and the disable for critical-word-first fills.

When the invalidate location is written, whatever the data, a sequencer walks every cache line index, one per clock. It drives a one-hot valid-clear vector into the tag array. During the walk the block forces the cache into bypass and clears the ready flag. Once the last line is cleared, ready returns and bypass again follows the enable bit. Software does not need to clear the enable bit before it starts a sweep.

Top module: `cache_ctl_regs`

## Requirements
- R1: After reset the control bits are all 0 (cache disabled, write-allocate off, critical-word-first on), ready is 1, no valid-clear line is active, and bypass is 1.
- R2: A read of offset 0x000 returns the identification word: release number in bits 5:0, part number in bits 9:6, cache ID in bits 15:10, and zeros above.
- R3: A read of offset 0x004 returns the cache size in bits 15:0 and the backing memory size in bits 31:16.
- R4: A write to offset 0x100 stores bit 0 (cache enable, 1 = on), bit 1 (write-allocate, 1 = on) and bit 2 (critical-word-first disable, 1 = feature off). These bits read back in the same positions and appear on `cache_en`, `wr_alloc_en` and `cwf_en` (which is the inverse of bit 2) from the cycle after the write. The other written bits are dropped.
- R5: At offset 0x100, bit 16 reads 1 when no sweep is running and 0 during a sweep. All other unused bits read 0.
- R6: A write of any value to offset 0x700 starts a sweep. In the k-th clock cycle after the write edge (k = 0 .. NUM_LINES-1), exactly bit k of `line_clr` is 1.
- R7: `ready` is 0 for the whole sweep. It rises NUM_LINES cycles after the write edge, which is the cycle after the last line is cleared.
- R8: `cache_bypass` is 1 whenever a sweep is running or the enable bit is 0, and 0 otherwise. A sweep started with the cache enabled leaves the enable bit set.
- R9: A write to offset 0x700 during a sweep restarts the sweep from line index 0. The full NUM_LINES-cycle walk then follows.
- R10: Reads of offset 0x700 and of every reserved offset return 0.
- R11: Writes to offsets 0x000, 0x004 and every reserved offset have no effect. The control bits, the identification word and the ready flag are unchanged, and no sweep starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| line_clr | output | NUM_LINES | One-hot valid-clear strobe per cache line |
| cache_bypass | output | 1 | Route accesses around the cache |
| cache_en | output | 1 | Cache enable bit |
| wr_alloc_en | output | 1 | Write-allocate policy enable |
| cwf_en | output | 1 | Critical-word-first fill enable |
| ready | output | 1 | No invalidation in progress |

## Verification
A wrong sweep index or busy flag shows up at once on `line_clr`. The bench samples it every cycle of every sweep, so a skipped, repeated or lingering line is caught in the first cycle where it differs. A busy flag that ends early or late shows as `ready` or `cache_bypass` being wrong exactly NUM_LINES cycles after the triggering write. A corrupted control register shows on the policy outputs and in the readback of offset 0x100 one cycle after the write that disturbed it, and the bench reads that word after every sweep over the reserved offsets.

// File: rtl/cctl_pkg.sv
package cctl_pkg;

  localparam int unsigned REG_AW = 12;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] OFF_IDENT = 12'h000;
  localparam logic [REG_AW-1:0] OFF_SIZES = 12'h004;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 12'h100;
  localparam logic [REG_AW-1:0] OFF_INVAL = 12'h700;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_WA_BIT   = 1;
  localparam int unsigned CTRL_CWFD_BIT = 2;
  localparam int unsigned CTRL_RDY_BIT  = 16;

  typedef struct packed {
    logic cwf_dis;
    logic wr_alloc;
    logic enable;
  } ctrl_t;

endpackage

// File: rtl/cctl_sweep.sv
module cctl_sweep #(
  parameter int unsigned NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  output logic                 busy_o,
  output logic [NUM_LINES-1:0] line_clr_o
);

  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             busy_q, busy_d;
  logic             step_en;

  // Next-state: start (or restart) at index 0, step, stop after the last line.
  always_comb begin
    idx_d  = idx_q;
    busy_d = busy_q;
    if (start_i) begin
      idx_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  assign step_en = start_i | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (step_en) begin
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_clr_dec
    assign line_clr_o[g] = busy_q && (idx_q == IDX_W'(g));
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_clr_o)) else $error("more than one line cleared"); // R6

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_q && idx_q == '0)) else $error("sweep not at index 0"); // R9

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start_i && idx_q != LAST_IDX) |=> (busy_q && idx_q == $past(idx_q) + 1'b1))
    else $error("sweep did not advance by one"); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start_i && idx_q == LAST_IDX) |=> !busy_q)
    else $error("sweep did not end after last line"); // R7

endmodule

// File: rtl/cctl_regs.sv
module cctl_regs
  import cctl_pkg::*;
#(
  parameter logic [5:0]  REL_NUM   = 6'h03,
  parameter logic [3:0]  PART_NUM  = 4'hA,
  parameter logic [5:0]  CACHE_TAG = 6'h15,
  parameter logic [15:0] CACHE_SZ  = 16'h0010,
  parameter logic [15:0] MEM_SZ    = 16'h0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              ready_i,
  output ctrl_t             ctrl_o,
  output logic              start_o,
  output logic [REG_DW-1:0] rdata_o
);

  localparam logic [REG_DW-1:0] IDENT_WORD = {16'h0000, CACHE_TAG, PART_NUM, REL_NUM};
  localparam logic [REG_DW-1:0] SIZES_WORD = {MEM_SZ, CACHE_SZ};

  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_we;

  assign ctrl_we = wr_i && (addr_i == OFF_CTRL);
  assign start_o = wr_i && (addr_i == OFF_INVAL);

  always_comb begin
    ctrl_d          = ctrl_q;
    ctrl_d.enable   = wdata_i[CTRL_EN_BIT];
    ctrl_d.wr_alloc = wdata_i[CTRL_WA_BIT];
    ctrl_d.cwf_dis  = wdata_i[CTRL_CWFD_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_IDENT: rdata_o = IDENT_WORD;
      OFF_SIZES: rdata_o = SIZES_WORD;
      OFF_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = ctrl_q.enable;
        rdata_o[CTRL_WA_BIT]   = ctrl_q.wr_alloc;
        rdata_o[CTRL_CWFD_BIT] = ctrl_q.cwf_dis;
        rdata_o[CTRL_RDY_BIT]  = ready_i;
      end
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q)) else $error("control changed without a write"); // R11

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q.enable == $past(wdata_i[CTRL_EN_BIT])))
    else $error("enable bit not loaded"); // R4

endmodule

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
  import cctl_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter logic [5:0]  REL_NUM   = 6'h03,
  parameter logic [3:0]  PART_NUM  = 4'hA,
  parameter logic [5:0]  CACHE_TAG = 6'h15,
  parameter logic [15:0] CACHE_SZ  = 16'h0010,
  parameter logic [15:0] MEM_SZ    = 16'h0800
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [11:0]          reg_addr,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NUM_LINES-1:0] line_clr,
  output logic                 cache_bypass,
  output logic                 cache_en,
  output logic                 wr_alloc_en,
  output logic                 cwf_en,
  output logic                 ready
);

  ctrl_t ctrl;
  logic  sweep_start;
  logic  sweep_busy;

  cctl_regs #(
    .REL_NUM  (REL_NUM),
    .PART_NUM (PART_NUM),
    .CACHE_TAG(CACHE_TAG),
    .CACHE_SZ (CACHE_SZ),
    .MEM_SZ   (MEM_SZ)
  ) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (reg_addr),
    .wr_i   (reg_wr),
    .wdata_i(reg_wdata),
    .ready_i(ready),
    .ctrl_o (ctrl),
    .start_o(sweep_start),
    .rdata_o(reg_rdata)
  );

  cctl_sweep #(
    .NUM_LINES(NUM_LINES)
  ) sweep_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (sweep_start),
    .busy_o    (sweep_busy),
    .line_clr_o(line_clr)
  );

  assign ready        = ~sweep_busy;
  assign cache_bypass = sweep_busy | ~ctrl.enable;
  assign cache_en     = ctrl.enable;
  assign wr_alloc_en  = ctrl.wr_alloc;
  assign cwf_en       = ~ctrl.cwf_dis;

  AST_BYPASS_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_clr) |-> (cache_bypass && !ready)) else $error("cache live during sweep"); // R8

  AST_INVAL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_INVAL) |=> line_clr[0]) else $error("sweep did not start"); // R6

endmodule

// File: tb/cache_ctl_regs_tb.sv
module cache_ctl_regs_tb_top;

  localparam int NL = 16;
  localparam logic [5:0]  REL  = 6'h03;
  localparam logic [3:0]  PART = 4'hA;
  localparam logic [5:0]  CTAG = 6'h15;
  localparam logic [15:0] CSZ  = 16'h0010;
  localparam logic [15:0] MSZ  = 16'h0800;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] line_clr;
  logic          cache_bypass, cache_en, wr_alloc_en, cwf_en, ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cache_ctl_regs #(
    .NUM_LINES(NL), .REL_NUM(REL), .PART_NUM(PART), .CACHE_TAG(CTAG),
    .CACHE_SZ(CSZ), .MEM_SZ(MSZ)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_clr(line_clr),
    .cache_bypass(cache_bypass), .cache_en(cache_en), .wr_alloc_en(wr_alloc_en),
    .cwf_en(cwf_en), .ready(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ident_word();
    return (32'(CTAG) << 10) + (32'(PART) << 6) + 32'(REL);
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [2:0] c,
                                           input logic rdy);
    if (a == 12'h000) return ident_word();
    if (a == 12'h004) return (32'(MSZ) << 16) + 32'(CSZ);
    if (a == 12'h100) return (rdy ? 32'h0001_0000 : 32'h0) + 32'(c);
    return 32'h0;
  endfunction

  // Drive at a falling edge, let one rising edge take it, return at the next falling edge.
  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  // Caller stands at the falling edge after the write edge (k = 0).
  task automatic sweep_chk(input string req, input int upto);
    for (int k = 0; k < upto; k++) begin
      chk({req, " line_clr"}, 32'(line_clr), 32'(1) << k);
      chk({req, " R7 ready low"}, 32'(ready), 32'd0);
      chk({req, " R8 bypass"}, 32'(cache_bypass), 32'd1);
      if (k < upto - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 line_clr", 32'(line_clr), 32'h0);
    chk("R1 ready", 32'(ready), 32'h1);
    chk("R1 bypass", 32'(cache_bypass), 32'h1);
    chk("R1 cache_en", 32'(cache_en), 32'h0);
    chk("R1 wr_alloc_en", 32'(wr_alloc_en), 32'h0);
    chk("R1 cwf_en", 32'(cwf_en), 32'h1);
    rd_chk("R1 R5 ctrl readback", 12'h100, 32'h0001_0000);

    // R2 R3 R10 full read sweep over the word space
    for (int a = 0; a < 4096; a += 4)
      rd_chk("R2 R3 R10 read", 12'(a), exp_read(12'(a), 3'b000, 1'b1));

    // R4 every control combination, with junk in the unused bits
    for (int v = 0; v < 8; v++) begin
      wr_reg(12'h100, 32'hFFF0_FFF8 | 32'(v));
      chk("R4 cache_en", 32'(cache_en), 32'(v & 1));
      chk("R4 wr_alloc_en", 32'(wr_alloc_en), 32'((v >> 1) & 1));
      chk("R4 cwf_en", 32'(cwf_en), 32'(((v >> 2) & 1) ^ 1));
      chk("R8 bypass idle", 32'(cache_bypass), 32'((v & 1) ^ 1));
      rd_chk("R4 R5 ctrl readback", 12'h100, 32'h0001_0000 | 32'(v));
    end

    // R11 writes to read-only and reserved words
    wr_reg(12'h100, 32'h5);
    for (int a = 0; a < 4096; a += 4) begin
      if (a != 12'h100 && a != 12'h700) begin
        wr_reg(12'(a), 32'hFFFF_FFFF);
        chk("R11 no sweep", {15'b0, ready, line_clr}, {15'b0, 1'b1, 16'h0});
      end
    end
    rd_chk("R11 ctrl unchanged", 12'h100, 32'h0001_0005);
    rd_chk("R11 ident unchanged", 12'h000, ident_word());

    // R6 R7 R8 sweep started while enabled, arbitrary data
    wr_reg(12'h100, 32'h1);
    wr_reg(12'h700, 32'hDEAD_BEEF);
    reg_addr = 12'h100;
    #1;
    chk("R5 ready bit reads 0", reg_rdata, 32'h0000_0001);
    sweep_chk("R6", NL);
    @(negedge clk);
    chk("R7 ready after sweep", 32'(ready), 32'h1);
    chk("R8 bypass off after sweep", 32'(cache_bypass), 32'h0);
    chk("R8 enable kept", 32'(cache_en), 32'h1);
    chk("R7 no clear after sweep", 32'(line_clr), 32'h0);
    rd_chk("R5 R10 ready bit back", 12'h100, 32'h0001_0001);
    rd_chk("R10 inval reads 0", 12'h700, 32'h0);

    // R9 restart part way, data zero
    wr_reg(12'h700, 32'h0);
    sweep_chk("R9 first", 6);
    wr_reg(12'h700, 32'h0);
    sweep_chk("R9 restart", NL);
    @(negedge clk);
    chk("R9 R7 ready after restart", 32'(ready), 32'h1);

    // R6 sweep while disabled: bypass stays on after it
    wr_reg(12'h100, 32'h0);
    wr_reg(12'h700, 32'h1);
    sweep_chk("R6 disabled", NL);
    @(negedge clk);
    chk("R7 ready", 32'(ready), 32'h1);
    chk("R8 bypass when disabled", 32'(cache_bypass), 32'h1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule